// File: doc/BRIEF.md
# JTAG Host Shift Engine

This block is the master end of a JTAG link. It produces the test clock from the system clock and drives the mode-select and data-in lines. It samples the data-out line from a single target TAP. A host issues one command at a time over a valid/ready handshake. There are four commands. One walks the TAP into Run-Test/Idle from any state. Two move from Run-Test/Idle or an Update state into Shift-IR or Shift-DR. The fourth shifts between 1 and 32 bits through whichever register is selected.

Each shift command has three options. The first sets the bit order, least significant or most significant first. The second asks the engine to leave the shift state on the last bit and stop in Update. The third, used with the second, asks it to go on into Run-Test/Idle. Without the exit option the TAP stays in Shift, and the next shift command continues the same scan. With exit but without return-to-idle, the TAP stops in Update, and the next move command goes from there straight into another scan without passing through Run-Test/Idle. When a command completes, the captured data-out word comes back on a one-cycle response strobe. A shift length outside 1 to 32 comes back flagged as an error.

Top module: `jtag_shift_master`

## Requirements
- R1: After synchronous reset `tck`, `tms` and `tdi` are all 1, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: The reset command (`cmd_op` = 0) gives exactly six rising `tck` edges with `tms` 1,1,1,1,1,0 at those edges. This leaves the TAP in Run-Test/Idle from any starting state.
- R3: The move-to-IR command (`cmd_op` = 1) gives four rising edges with `tms` 1,1,0,0. The move-to-DR command (`cmd_op` = 2) gives three rising edges with `tms` 1,0,0. Starting from Run-Test/Idle or from either Update state, each ends in the matching Shift state.
- R4: Each TCK bit holds `tck` low for exactly TCK_DIV/2 system clocks and then high for at least TCK_DIV/2 clocks. `tck` is high whenever `cmd_ready` is 1, and `tms`/`tdi` do not change while `tck` stays low.
- R5: With `cmd_msb` = 0 the shift command (`cmd_op` = 3) sends `cmd_data[0]` first, up to `cmd_data[N-1]`. The k-th sampled TDO bit ends up in `rsp_data[k]`, and bits N and above are 0.
- R6: With `cmd_msb` = 1 it sends `cmd_data[N-1]` first, down to `cmd_data[0]`. The k-th sampled TDO bit ends up in `rsp_data[N-1-k]`, and bits N and above are 0.
- R7: With `cmd_exit` = 1, `tms` is 0 on every data bit except the last, where it is 1. One further edge with `tms` = 1 then puts the TAP in Update. With `cmd_exit` = 0 there are exactly N edges, all with `tms` = 0, and the TAP stays in Shift, so a following shift continues the same scan.
- R8: With `cmd_exit` = 1 and `cmd_idle` = 1, one more edge with `tms` = 0 enters Run-Test/Idle. With `cmd_idle` = 0 the engine stops in Update, and `cmd_idle` has no effect when `cmd_exit` = 0.
- R9: `tdi` is 1 once a shift command completes and stays 1 through any exit or idle cycles. It is 1 whenever `cmd_ready` is 1.
- R10: A shift command with `cmd_len` of 0 or above 32 produces no `tck` edge. It is answered on the cycle after acceptance with `rsp_err` = 1 and `rsp_data` = 0, and the TAP state is unchanged.
- R11: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the next cycle until the command completes. A completed command gives a single-cycle `rsp_valid` with `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and accepting a command |
| cmd_op | input | 2 | 0 reset TAP, 1 move to Shift-IR, 2 move to Shift-DR, 3 shift bits |
| cmd_len | input | 6 | Shift length N (valid 1 to 32) |
| cmd_msb | input | 1 | 1 shifts most significant bit first |
| cmd_exit | input | 1 | 1 leaves the shift state on the last bit |
| cmd_idle | input | 1 | With exit, 1 continues into Run-Test/Idle |
| cmd_data | input | 32 | Word to send on TDI |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Command rejected for bad length |
| rsp_data | output | 32 | Captured TDO word (0 for moves and rejects) |
| tck | output | 1 | Test clock, idles high |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
Two sequences are the hard ones to reach. One stops in Update and goes straight into the next scan. The other spans one scan over two or more commands that stay in Shift. A port-level view cannot show either, because the TAP state exists only in the target. The bench therefore runs a full sixteen-state TAP model on the engine's own `tck` and `tms`. The model records what arrives on TDI and serves a known stream on TDO, so the bench can chain no-exit, exit-without-idle and move-from-Update commands and check both the state reached and the continuity of bit positions across commands. The reset command is first applied with the model parked in Shift-DR, so it has to recover from a state other than idle.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

    // Command opcodes as carried on cmd_op
    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_TO_IR = 2'd1,
        OP_TO_DR = 2'd2,
        OP_SHIFT = 2'd3
    } jsm_op_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MOVE = 2'd1,
        PH_DATA = 2'd2
    } jsm_phase_e;

    // TCK bit-cycle generator states
    typedef enum logic [1:0] {
        RN_IDLE = 2'd0,
        RN_LOW  = 2'd1,
        RN_HIGH = 2'd2
    } jsm_run_e;

    // A fixed TMS walk: number of TCK cycles and the TMS values,
    // issued starting from bit 0
    typedef struct packed {
        logic [2:0] n;
        logic [5:0] pat;
    } tms_route_t;

    function automatic tms_route_t tms_route(jsm_op_e op);
        tms_route_t r;
        case (op)
            OP_RESET: r = '{n: 3'd6, pat: 6'b011111};
            OP_TO_IR: r = '{n: 3'd4, pat: 6'b000011};
            OP_TO_DR: r = '{n: 3'd3, pat: 6'b000001};
            default:  r = '{n: 3'd0, pat: 6'b000000};
        endcase
        return r;
    endfunction

    // Tail after an exiting shift: one TMS-high cycle, plus an
    // optional TMS-low cycle into Run-Test/Idle
    function automatic tms_route_t tail_route(logic to_idle);
        tms_route_t r;
        r.pat = 6'b000001;
        r.n   = to_idle ? 3'd2 : 3'd1;
        return r;
    endfunction

endpackage

// File: rtl/jsm_tck_gen.sv
module jsm_tck_gen
    import jsm_pkg::*;
#(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic tck,
    output logic done
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    jsm_run_e       st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= RN_IDLE;
            tck <= 1'b1;
            cnt <= '0;
        end else begin
            case (st)
                RN_IDLE: begin
                    if (go) begin
                        st  <= RN_LOW;
                        tck <= 1'b0;
                        cnt <= '0;
                    end
                end
                RN_LOW: begin
                    if (cnt == LAST) begin
                        st  <= RN_HIGH;
                        tck <= 1'b1;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RN_HIGH: begin
                    if (cnt == LAST) begin
                        st <= RN_IDLE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= RN_IDLE;
            endcase
        end
    end

    // Last system clock of the high phase: TDO is taken here
    assign done = (st == RN_HIGH) && (cnt == LAST);

endmodule

// File: rtl/jsm_shreg.sv
module jsm_shreg #(
    parameter int unsigned W  = 32,
    parameter int unsigned LW = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] data,
    input  logic [LW-1:0] len,
    input  logic         msb,
    input  logic         adv,
    input  logic         cap,
    input  logic         tdo,
    output logic         cur_bit,
    output logic [W-1:0] rx_word
);
    localparam int unsigned IW = $clog2(W);

    logic [W-1:0]  tx;
    logic [W-1:0]  rx;
    logic [IW-1:0] top_q;
    logic          msb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx    <= '0;
            rx    <= '0;
            top_q <= '0;
            msb_q <= 1'b0;
        end else if (load) begin
            tx    <= data;
            rx    <= '0;
            top_q <= IW'(len - LW'(1));
            msb_q <= msb;
        end else begin
            if (adv) begin
                tx <= msb_q ? (tx << 1) : (tx >> 1);
            end
            if (cap) begin
                if (msb_q) begin
                    rx <= {rx[W-2:0], tdo};
                end else begin
                    rx <= (rx >> 1) | (W'(tdo) << top_q);
                end
            end
        end
    end

    assign cur_bit = msb_q ? tx[top_q] : tx[0];
    assign rx_word = rx;

endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master
    import jsm_pkg::*;
#(
    parameter int unsigned MAX_BITS = 32,
    parameter int unsigned TCK_DIV  = 4,
    localparam int unsigned LW = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [LW-1:0]       cmd_len,
    input  logic                cmd_msb,
    input  logic                cmd_exit,
    input  logic                cmd_idle,
    input  logic [MAX_BITS-1:0] cmd_data,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [MAX_BITS-1:0] rsp_data,
    output logic                tck,
    output logic                tms,
    output logic                tdi,
    input  logic                tdo
);
    localparam int unsigned HALF = (TCK_DIV >= 4) ? (TCK_DIV / 2) : 1;

    jsm_phase_e          ph;
    jsm_op_e             op;
    tms_route_t          route;
    tms_route_t          tail;
    logic                inflight;
    logic                is_shift;
    logic                exit_q;
    logic                idle_q;
    logic [2:0]          mv_left;
    logic [5:0]          mv_pat;
    logic [LW-1:0]       bits_left;
    logic                accept;
    logic                len_ok;
    logic                load;
    logic                go;
    logic                go_move;
    logic                adv;
    logic                cap;
    logic                bit_done;
    logic                cur_bit;
    logic [MAX_BITS-1:0] rx_word;

    assign op        = jsm_op_e'(cmd_op);
    assign route     = tms_route(op);
    assign tail      = tail_route(idle_q);
    assign cmd_ready = (ph == PH_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign len_ok    = (cmd_len != '0) && (cmd_len <= LW'(MAX_BITS));
    assign load      = accept && (op == OP_SHIFT) && len_ok;
    assign go_move   = (ph == PH_MOVE) && !inflight && (mv_left != 3'd0);
    assign adv       = (ph == PH_DATA) && !inflight && (bits_left != '0);
    assign go        = go_move || adv;
    assign cap       = (ph == PH_DATA) && bit_done;

    jsm_tck_gen #(.HALF(HALF)) u_tck (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .tck  (tck),
        .done (bit_done)
    );

    jsm_shreg #(.W(MAX_BITS), .LW(LW)) u_sh (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .data    (cmd_data),
        .len     (cmd_len),
        .msb     (cmd_msb),
        .adv     (adv),
        .cap     (cap),
        .tdo     (tdo),
        .cur_bit (cur_bit),
        .rx_word (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            tms       <= 1'b1;
            tdi       <= 1'b1;
            inflight  <= 1'b0;
            is_shift  <= 1'b0;
            exit_q    <= 1'b0;
            idle_q    <= 1'b0;
            mv_left   <= 3'd0;
            mv_pat    <= 6'd0;
            bits_left <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (go) begin
                inflight <= 1'b1;
            end else if (bit_done) begin
                inflight <= 1'b0;
            end

            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        is_shift <= (op == OP_SHIFT);
                        exit_q   <= cmd_exit;
                        idle_q   <= cmd_idle;
                        if (op != OP_SHIFT) begin
                            mv_left <= route.n;
                            mv_pat  <= route.pat;
                            ph      <= PH_MOVE;
                        end else if (len_ok) begin
                            bits_left <= cmd_len;
                            ph        <= PH_DATA;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_data  <= '0;
                        end
                    end
                end

                PH_MOVE: begin
                    if (go_move) begin
                        tms     <= mv_pat[0];
                        tdi     <= 1'b1;
                        mv_pat  <= {1'b0, mv_pat[5:1]};
                        mv_left <= mv_left - 3'd1;
                    end else if (!inflight && (mv_left == 3'd0)) begin
                        ph        <= PH_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_data  <= is_shift ? rx_word : '0;
                    end
                end

                PH_DATA: begin
                    if (adv) begin
                        tms       <= exit_q && (bits_left == LW'(1));
                        tdi       <= cur_bit;
                        bits_left <= bits_left - LW'(1);
                    end else if (!inflight && (bits_left == '0)) begin
                        tdi <= 1'b1;
                        if (exit_q) begin
                            mv_left <= tail.n;
                            mv_pat  <= tail.pat;
                            ph      <= PH_MOVE;
                        end else begin
                            ph        <= PH_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b0;
                            rsp_data  <= rx_word;
                        end
                    end
                end

                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/jsm_checker.sv
module jsm_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       tck,
    input logic       tms,
    input logic       tdi
);
    // R4: the clock rests high whenever the engine is idle
    p_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> tck);

    // R4: pins only move on the edge that drops tck
    p_pins_hold_low_r4: assert property (@(posedge clk) disable iff (rst)
        (!tck && !$past(tck)) |-> ($stable(tms) && $stable(tdi)));

    // R9: data line parked high between commands
    p_tdi_park_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> tdi);

    // R10: a rejected command saw no clock activity
    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (tck && $past(tck) && cmd_ready));

    // R11: a non-shift command always makes the engine busy
    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && (cmd_op != 2'd3)) |=> !cmd_ready);

    // R11: a completion strobe lasts one cycle
    p_single_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |=> !rsp_valid);

endmodule

bind jtag_shift_master jsm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .tck       (tck),
    .tms       (tms),
    .tdi       (tdi)
);

// File: tb/sim_jtag_shift_master.sv
module sim_jtag_shift_master;
    import jsm_pkg::*;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned W        = 32;
    localparam int unsigned DIV      = 4;
    localparam int unsigned HALF     = DIV / 2;
    localparam int unsigned LW       = $clog2(W + 1);
    localparam int unsigned WATCHDOG = 150000;

    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PADR, T_EX2DR,
        T_UPDR, T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAIR, T_EX2IR, T_UPIR
    } tap_e;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_msb = 1'b0;
    logic          cmd_exit = 1'b0;
    logic          cmd_idle = 1'b0;
    logic [W-1:0]  cmd_data = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [W-1:0]  rsp_data;
    logic          tck;
    logic          tms;
    logic          tdi;
    logic          tdo = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    jtag_shift_master #(.MAX_BITS(W), .TCK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_msb(cmd_msb),
        .cmd_exit(cmd_exit), .cmd_idle(cmd_idle), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    // ---------------- target TAP model ----------------
    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            T_TLR:   return m ? T_TLR   : T_RTI;
            T_RTI:   return m ? T_SELDR : T_RTI;
            T_SELDR: return m ? T_SELIR : T_CAPDR;
            T_CAPDR: return m ? T_EX1DR : T_SHDR;
            T_SHDR:  return m ? T_EX1DR : T_SHDR;
            T_EX1DR: return m ? T_UPDR  : T_PADR;
            T_PADR:  return m ? T_EX2DR : T_PADR;
            T_EX2DR: return m ? T_UPDR  : T_SHDR;
            T_UPDR:  return m ? T_SELDR : T_RTI;
            T_SELIR: return m ? T_TLR   : T_CAPIR;
            T_CAPIR: return m ? T_EX1IR : T_SHIR;
            T_SHIR:  return m ? T_EX1IR : T_SHIR;
            T_EX1IR: return m ? T_UPIR  : T_PAIR;
            T_PAIR:  return m ? T_EX2IR : T_PAIR;
            T_EX2IR: return m ? T_UPIR  : T_SHIR;
            default: return m ? T_SELDR : T_RTI;
        endcase
    endfunction

    tap_e        tap = T_SHDR;
    int          tcnt = 0;
    logic [63:0] trecv = '0;
    logic [63:0] tsend = '0;
    int          rises = 0;
    logic [63:0] thist = '0;

    always @(posedge tck) begin
        rises = rises + 1;
        thist = {thist[62:0], tms};
        if (tap == T_SHDR || tap == T_SHIR) begin
            if (tcnt < 64) trecv[tcnt] = tdi;
            tcnt = tcnt + 1;
        end
        tap = tap_next(tap, tms);
        if (tap == T_CAPDR || tap == T_CAPIR) begin
            tcnt  = 0;
            trecv = '0;
        end
    end

    always @(negedge tck) begin
        if ((tap == T_SHDR || tap == T_SHIR) && tcnt < 64) tdo = tsend[tcnt];
    end

    // ---------------- TCK phase timing monitor ----------------
    int  lo_run = 0;
    int  hi_run = HALF;
    int  tbad = 0;
    int  tmeas = 0;
    logic prev_tck = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!tck) begin
                if (prev_tck && hi_run < HALF) tbad = tbad + 1;
                lo_run = lo_run + 1;
                hi_run = 0;
            end else begin
                if (!prev_tck) begin
                    tmeas = tmeas + 1;
                    if (lo_run != HALF) tbad = tbad + 1;
                end
                hi_run = hi_run + 1;
                lo_run = 0;
            end
            prev_tck = tck;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R11 watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (ok !== 1'b1) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [W-1:0] got_data;
    logic         got_err;
    logic         ready_after;
    logic         valid_after;

    task automatic issue(input logic [1:0] op, input int len, input logic msb,
                         input logic ex, input logic idl, input logic [W-1:0] data);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_len   = LW'(len);
        cmd_msb   = msb;
        cmd_exit  = ex;
        cmd_idle  = idl;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid   = 1'b0;
        ready_after = cmd_ready;
        while (!rsp_valid) @(negedge clk);
        got_data = rsp_data;
        got_err  = rsp_err;
        @(negedge clk);
        valid_after = rsp_valid;
    endtask

    task automatic move(input logic [1:0] op, input int n_exp,
                        input logic [5:0] seq_exp, input tap_e st_exp, input string tag);
        rises = 0;
        thist = '0;
        issue(op, 0, 1'b0, 1'b0, 1'b0, '0);
        chk(rises == n_exp, {tag, " edge count"}, 64'(rises), 64'(n_exp));
        chk(thist[5:0] == seq_exp, {tag, " tms sequence"}, thist, 64'(seq_exp));
        chk(tap == st_exp, {tag, " tap state"}, 64'(tap), 64'(st_exp));
        chk(got_err == 1'b0 && got_data == '0, "R11 move response", {31'd0, got_err, got_data}, 64'd0);
        chk(ready_after == 1'b0 && valid_after == 1'b0, "R11 busy and single strobe",
            {ready_after, valid_after}, 64'd0);
    endtask

    task automatic shift_chk(input int n, input logic msb, input logic ex, input logic idl,
                             input logic [W-1:0] data, input tap_e st_exp);
        int          base;
        int          tot;
        int          bad_rx;
        logic [63:0] exp_rsp;
        logic [63:0] exp_hist;
        logic [63:0] mask;
        logic        sb;
        string       tag;
        tag   = msb ? "R6" : "R5";
        base  = tcnt;
        rises = 0;
        thist = '0;
        issue(2'd3, n, msb, ex, idl, data);
        exp_rsp = '0;
        bad_rx  = 0;
        for (int k = 0; k < n; k++) begin
            sb = msb ? data[n - 1 - k] : data[k];
            if (trecv[base + k] !== sb) bad_rx = bad_rx + 1;
            if (msb) exp_rsp[n - 1 - k] = tsend[base + k];
            else     exp_rsp[k]         = tsend[base + k];
        end
        exp_hist = '0;
        for (int k = 0; k < n; k++) exp_hist = {exp_hist[62:0], (ex && k == n - 1)};
        tot = n;
        if (ex) begin
            exp_hist = {exp_hist[62:0], 1'b1};
            tot = tot + 1;
            if (idl) begin
                exp_hist = {exp_hist[62:0], 1'b0};
                tot = tot + 1;
            end
        end
        mask = (tot >= 64) ? '1 : ((64'd1 << tot) - 64'd1);
        chk(64'(got_data) == exp_rsp && got_err == 1'b0, {tag, " captured word"},
            64'(got_data), exp_rsp);
        chk(bad_rx == 0, {tag, " bits seen on tdi"}, 64'(bad_rx), 64'd0);
        chk(rises == tot, "R7 edge count", 64'(rises), 64'(tot));
        chk((thist & mask) == exp_hist, "R7 tms pattern", thist & mask, exp_hist);
        chk(tap == st_exp, "R8 tap state after shift", 64'(tap), 64'(st_exp));
        chk(tdi == 1'b1 && tck == 1'b1, "R9 tdi high, R4 tck idle high", {tdi, tck}, 64'd3);
        chk(ready_after == 1'b0 && valid_after == 1'b0, "R11 busy and single strobe",
            {ready_after, valid_after}, 64'd0);
    endtask

    function automatic logic [31:0] lcg(logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    // ---------------- main sequence ----------------
    logic [31:0] seed;
    int          r0;
    tap_e        s0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(tck === 1'b1 && tms === 1'b1 && tdi === 1'b1, "R1 pins after reset",
            {tck, tms, tdi}, 64'd7);
        chk(cmd_ready === 1'b1 && rsp_valid === 1'b0, "R1 handshake after reset",
            {cmd_ready, rsp_valid}, 64'd2);

        // R2 reset walk, starting with the target parked in Shift-DR
        move(2'd0, 6, 6'b111110, T_RTI, "R2");

        // R3 to Shift-IR from idle, then an IR scan back to idle
        move(2'd1, 4, 6'b001100, T_SHIR, "R3 IR");
        tsend = 64'h0000_0000_0000_0009;
        shift_chk(4, 1'b0, 1'b1, 1'b1, 32'h0000_0005, T_RTI);

        // R5 R6 R7 R8 sweep every length in both orders
        seed = 32'h1234_5678;
        for (int n = 1; n <= 32; n++) begin
            for (int m = 0; m < 2; m++) begin
                move(2'd2, 3, 6'b000100, T_SHDR, "R3 DR");
                seed  = lcg(seed);
                tsend[31:0] = seed;
                seed  = lcg(seed);
                tsend[63:32] = seed;
                seed  = lcg(seed);
                shift_chk(n, m[0], 1'b1, 1'b1, seed, T_RTI);
            end
        end

        // R7 scan split across commands that stay in Shift-DR
        move(2'd2, 3, 6'b000100, T_SHDR, "R3 DR");
        tsend = 64'hC3A5_0F1E_96D2_7B48;
        shift_chk(8, 1'b0, 1'b0, 1'b1, 32'h0000_00B6, T_SHDR);
        chk(tms == 1'b0, "R7 tms low while left in shift", 64'(tms), 64'd0);
        shift_chk(8, 1'b1, 1'b1, 1'b0, 32'h0000_0071, T_UPDR);

        // R8 from Update-DR straight into the next scans
        move(2'd2, 3, 6'b000100, T_SHDR, "R8 DR from update");
        tsend = 64'h0123_4567_89AB_CDEF;
        shift_chk(16, 1'b1, 1'b1, 1'b0, 32'h0000_BEEF, T_UPDR);
        move(2'd1, 4, 6'b001100, T_SHIR, "R8 IR from update");
        shift_chk(4, 1'b0, 1'b1, 1'b0, 32'h0000_000C, T_UPIR);
        move(2'd1, 4, 6'b001100, T_SHIR, "R3 IR from update");
        shift_chk(4, 1'b1, 1'b1, 1'b1, 32'h0000_0003, T_RTI);

        // R10 bad lengths: no clock, error response, TAP untouched
        for (int i = 0; i < 3; i++) begin
            int bad_len;
            bad_len = (i == 0) ? 0 : ((i == 1) ? 33 : 63);
            r0 = rises;
            s0 = tap;
            issue(2'd3, bad_len, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF);
            chk(got_err == 1'b1 && got_data == '0, "R10 error response",
                {31'd0, got_err, got_data}, 64'h1_0000_0000);
            chk(rises == r0 && tap == s0, "R10 no tck edges", 64'(rises - r0), 64'd0);
            chk(ready_after == 1'b1, "R10 engine stays ready", 64'(ready_after), 64'd1);
        end

        // R2 once more, from Run-Test/Idle
        move(2'd0, 6, 6'b111110, T_TLR == T_TLR ? T_RTI : T_RTI, "R2 repeat");

        chk(tbad == 0 && tmeas > 0, "R4 tck phase lengths", 64'(tbad), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule